// File: doc/BRIEF.md
# NAND Geometry Record Loader

This block runs once at boot, on a start pulse, to fetch a small geometry record for a NAND device out of a serial EEPROM. It does not toggle the bus lines itself. It drives a byte-level I2C engine through a command channel (start condition, stop condition, write a byte, read a byte) and takes one response back for each command. The EEPROM is read at random: the block selects the device for writing, sends the memory offset, issues a repeated start, selects the device for reading and then pulls in seven bytes.

When the read completes, the block compares the first four bytes against a fixed signature. It then decodes the remaining three bytes into values the NAND controller can use directly:
- the number of column and row address bytes;
- the page size in bytes;
- the number of pages per block;
- the bus width;
- the ECC mode.

Done, valid and error report the outcome. They hold until the next start pulse.

The command channel uses valid/ready. The block raises `cmd_valid` and keeps the command fields steady until `cmd_ready` is seen high on a clock edge. Only one command is outstanding at a time. The response channel also uses valid/ready. The block raises `rsp_ready` only while it waits for the response to the command just accepted, and the engine may hold `rsp_valid` back for as many cycles as it needs.

Top module: `nand_geom_loader`

## Requirements
- R1: After reset, done, valid and error are low, no command is offered, and every decoded output is zero.
- R2: A start pulse produces exactly this command order. Command codes are START=0, STOP=1, WRITE=2, READ=3. The order is: START; WRITE 0xA0 (device 0x50, write); WRITE 0x80; START; WRITE 0xA1 (device 0x50, read); seven READs; STOP.
- R3: `cmd_last` is 0 on the first six READs so that they are acknowledged. It is 1 on the seventh READ so that it is not acknowledged.
- R4: If any of the three WRITE bytes returns `rsp_ack`=0, the next command is STOP and no READ is issued. The run then ends with error high and valid low.
- R5: The record is rejected (error high, valid low) unless bytes 0..3 read are 0x10, 0xB3, 0x57, 0xA6 in that order.
- R6: Byte 4 gives `col_bytes` from bits [7:4] and `row_bytes` from bits [3:0].
- R7: `page_bytes` equals 2 raised to byte 5. `blk_pages` equals 2 raised to byte 6 bits [3:0].
- R8: Byte 6 bit 4 gives `bus16` (1 = 16-bit). Byte 6 bits [6:5] give `ecc_mode` (0 none, 1 BCH 8-bit, 2 BCH 16-bit).
- R9: An ECC code of 3, or a page exponent of PAGE_W or more, rejects the record.
- R10: At most one of valid and error is ever high, and neither is high without done. Every decoded output reads zero while valid is low.
- R11: Done stays high until the next start pulse. That pulse clears done, valid and error on the following cycle. A start pulse during a run is ignored.
- R12: While `cmd_valid` is high and `cmd_ready` is low, the command fields stay stable. `cmd_valid` and `rsp_ready` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to load the record |
| cmd_valid | output | 1 | Command offered to the byte engine |
| cmd_ready | input | 1 | Byte engine accepts the command |
| cmd_op | output | 2 | 0 START, 1 STOP, 2 WRITE, 3 READ |
| cmd_wdata | output | 8 | Byte to send for WRITE |
| cmd_last | output | 1 | For READ, answer with NACK instead of ACK |
| rsp_valid | input | 1 | Response to the last command |
| rsp_ready | output | 1 | Block waits for a response |
| rsp_data | input | 8 | Byte returned by READ |
| rsp_ack | input | 1 | For WRITE, the target acknowledged |
| done | output | 1 | Run finished |
| valid | output | 1 | Record accepted, decoded outputs usable |
| err | output | 1 | NACK or rejected record |
| col_bytes | output | 4 | Column address byte count |
| row_bytes | output | 4 | Row address byte count |
| page_bytes | output | PAGE_W | Page size in bytes |
| blk_pages | output | 16 | Pages per block |
| bus16 | output | 1 | NAND bus is 16 bits wide |
| ecc_mode | output | 2 | ECC scheme code |

## Verification
The bench builds the block with its default parameters: device 0x50, offset 0x80, the four-byte signature and a 32-bit page size output. With a 32-bit page size output, a page exponent taken from a full byte can exceed the output width, so the out-of-range rejection is reachable alongside the ECC-code rejection. The responder answers each command after one cycle. Its NACK can be placed on any of the three WRITE bytes, and its record contents can be altered per test, which reaches every early-stop path and the signature mismatch.

// File: rtl/ngl_pkg.sv
package ngl_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } i2c_op_e;

  localparam int REC_BYTES = 7;
endpackage

// File: rtl/ngl_seq.sv
module ngl_seq
  import ngl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter logic [7:0] MEM_OFS  = 8'h80,
  parameter int         IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output i2c_op_e          cmd_op,
  output logic [7:0]       cmd_wdata,
  output logic             cmd_last,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic             rsp_ack,
  output logic             cap_en,
  output logic [IDX_W-1:0] cap_idx,
  input  logic             rec_ok,
  output logic             done,
  output logic             valid,
  output logic             err
);
  localparam int STOP_I = 5 + REC_BYTES;
  localparam int STEP_W = $clog2(STOP_I + 1);
  localparam logic [STEP_W-1:0] ST_ADDRW = STEP_W'(1);
  localparam logic [STEP_W-1:0] ST_OFS   = STEP_W'(2);
  localparam logic [STEP_W-1:0] ST_RSTRT = STEP_W'(3);
  localparam logic [STEP_W-1:0] ST_ADDRR = STEP_W'(4);
  localparam logic [STEP_W-1:0] ST_RD0   = STEP_W'(5);
  localparam logic [STEP_W-1:0] ST_RDN   = STEP_W'(STOP_I - 1);
  localparam logic [STEP_W-1:0] ST_STOP  = STEP_W'(STOP_I);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_e;

  st_e               state;
  logic [STEP_W-1:0] step;
  logic              nack_seen;
  logic              is_write;
  logic              is_read;

  assign is_write = (step == ST_ADDRW) || (step == ST_OFS) || (step == ST_ADDRR);
  assign is_read  = (step >= ST_RD0) && (step <= ST_RDN);

  always_comb begin
    cmd_op    = OP_START;
    cmd_wdata = 8'h00;
    cmd_last  = 1'b0;
    if (step == ST_ADDRW) begin
      cmd_op    = OP_WRITE;
      cmd_wdata = {DEV_ADDR, 1'b0};
    end else if (step == ST_OFS) begin
      cmd_op    = OP_WRITE;
      cmd_wdata = MEM_OFS;
    end else if (step == ST_ADDRR) begin
      cmd_op    = OP_WRITE;
      cmd_wdata = {DEV_ADDR, 1'b1};
    end else if (is_read) begin
      cmd_op   = OP_READ;
      cmd_last = (step == ST_RDN);
    end else if (step == ST_STOP) begin
      cmd_op = OP_STOP;
    end
  end

  assign cmd_valid = (state == S_ISSUE);
  assign rsp_ready = (state == S_WAIT);
  assign cap_en    = (state == S_WAIT) && rsp_valid && is_read;
  assign cap_idx   = IDX_W'(step - ST_RD0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      step      <= '0;
      nack_seen <= 1'b0;
      done      <= 1'b0;
      valid     <= 1'b0;
      err       <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          done      <= 1'b0;
          valid     <= 1'b0;
          err       <= 1'b0;
          nack_seen <= 1'b0;
          step      <= '0;
          state     <= S_ISSUE;
        end
        S_ISSUE: if (cmd_ready) state <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          if (step == ST_STOP) begin
            state <= S_IDLE;
            done  <= 1'b1;
            err   <= nack_seen || !rec_ok;
            valid <= !nack_seen && rec_ok;
          end else if (is_write && !rsp_ack) begin
            nack_seen <= 1'b1;
            step      <= ST_STOP;
            state     <= S_ISSUE;
          end else begin
            step  <= step + STEP_W'(1);
            state <= S_ISSUE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic unused_rstrt;
  assign unused_rstrt = (step == ST_RSTRT);
endmodule

// File: rtl/ngl_rec.sv
module ngl_rec
  import ngl_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cap_en,
  input  logic [IDX_W-1:0]              cap_idx,
  input  logic [7:0]                    din,
  output logic [REC_BYTES-1:0][7:0]     rec
);
  for (genvar g = 0; g < REC_BYTES; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rec[g] <= 8'h00;
      else if (cap_en && (cap_idx == IDX_W'(g))) rec[g] <= din;
    end
  end
endmodule

// File: rtl/ngl_decode.sv
module ngl_decode
  import ngl_pkg::*;
#(
  parameter logic [31:0] SIGNATURE = 32'h10B3_57A6,
  parameter int          PAGE_W    = 32
) (
  input  logic [REC_BYTES-1:0][7:0] rec,
  input  logic                      en,
  output logic                      rec_ok,
  output logic [3:0]                col_bytes,
  output logic [3:0]                row_bytes,
  output logic [PAGE_W-1:0]         page_bytes,
  output logic [15:0]               blk_pages,
  output logic                      bus16,
  output logic [1:0]                ecc_mode
);
  logic       sig_ok;
  logic       pexp_ok;
  logic [1:0] ecc_raw;
  logic       unused_rsvd;

  assign sig_ok      = ({rec[0], rec[1], rec[2], rec[3]} == SIGNATURE);
  assign pexp_ok     = (int'(rec[5]) < PAGE_W);
  assign ecc_raw     = rec[6][6:5];
  assign rec_ok      = sig_ok && pexp_ok && (ecc_raw != 2'd3);
  assign unused_rsvd = rec[6][7];

  always_comb begin
    col_bytes  = '0;
    row_bytes  = '0;
    page_bytes = '0;
    blk_pages  = '0;
    bus16      = 1'b0;
    ecc_mode   = '0;
    if (en) begin
      col_bytes  = rec[4][7:4];
      row_bytes  = rec[4][3:0];
      page_bytes = PAGE_W'(1) << rec[5];
      blk_pages  = 16'(1) << rec[6][3:0];
      bus16      = rec[6][4];
      ecc_mode   = ecc_raw;
    end
  end
endmodule

// File: rtl/nand_geom_loader.sv
module nand_geom_loader
  import ngl_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR  = 7'h50,
  parameter logic [7:0]  MEM_OFS   = 8'h80,
  parameter logic [31:0] SIGNATURE = 32'h10B3_57A6,
  parameter int          PAGE_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [7:0]        cmd_wdata,
  output logic              cmd_last,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [7:0]        rsp_data,
  input  logic              rsp_ack,
  output logic              done,
  output logic              valid,
  output logic              err,
  output logic [3:0]        col_bytes,
  output logic [3:0]        row_bytes,
  output logic [PAGE_W-1:0] page_bytes,
  output logic [15:0]       blk_pages,
  output logic              bus16,
  output logic [1:0]        ecc_mode
);
  localparam int IDX_W = $clog2(REC_BYTES);

  i2c_op_e                   op;
  logic                      cap_en;
  logic [IDX_W-1:0]          cap_idx;
  logic                      rec_ok;
  logic [REC_BYTES-1:0][7:0] rec;

  assign cmd_op = op;

  ngl_seq #(.DEV_ADDR(DEV_ADDR), .MEM_OFS(MEM_OFS), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(op),
    .cmd_wdata(cmd_wdata), .cmd_last(cmd_last),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ack(rsp_ack),
    .cap_en(cap_en), .cap_idx(cap_idx), .rec_ok(rec_ok),
    .done(done), .valid(valid), .err(err)
  );

  ngl_rec #(.IDX_W(IDX_W)) u_rec (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(cap_idx),
    .din(rsp_data), .rec(rec)
  );

  ngl_decode #(.SIGNATURE(SIGNATURE), .PAGE_W(PAGE_W)) u_dec (
    .rec(rec), .en(valid), .rec_ok(rec_ok),
    .col_bytes(col_bytes), .row_bytes(row_bytes), .page_bytes(page_bytes),
    .blk_pages(blk_pages), .bus16(bus16), .ecc_mode(ecc_mode)
  );
endmodule

// File: rtl/ngl_checker.sv
module ngl_checker #(
  parameter int PAGE_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic [7:0]        cmd_wdata,
  input logic              cmd_last,
  input logic              rsp_ready,
  input logic              done,
  input logic              valid,
  input logic              err,
  input logic [PAGE_W-1:0] page_bytes
);
  a_r12_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_wdata) && $stable(cmd_last));

  a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && rsp_ready));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && err));

  a_r10_flags_need_done: assert property (@(posedge clk) disable iff (!rst_n)
    (valid || err) |-> done);

  a_r10_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (valid != err));

  a_r11_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  a_r11_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start && !cmd_valid && !rsp_ready |=> !done && cmd_valid);

  a_r10_page_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !valid && !done |-> page_bytes == '0);
endmodule

bind nand_geom_loader ngl_checker #(.PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
  .cmd_last(cmd_last), .rsp_ready(rsp_ready), .done(done), .valid(valid),
  .err(err), .page_bytes(page_bytes)
);

// File: tb/nand_geom_loader_tb.sv
`timescale 1ns/1ps
module nand_geom_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cmd_valid, cmd_ready;
  logic [1:0]  cmd_op;
  logic [7:0]  cmd_wdata;
  logic        cmd_last;
  logic        rsp_valid, rsp_ready;
  logic [7:0]  rsp_data;
  logic        rsp_ack;
  logic        done, valid, err;
  logic [3:0]  col_bytes, row_bytes;
  logic [31:0] page_bytes;
  logic [15:0] blk_pages;
  logic        bus16;
  logic [1:0]  ecc_mode;

  always #4 clk = ~clk;

  nand_geom_loader u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .cmd_last(cmd_last),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_ack(rsp_ack), .done(done), .valid(valid), .err(err),
    .col_bytes(col_bytes), .row_bytes(row_bytes), .page_bytes(page_bytes),
    .blk_pages(blk_pages), .bus16(bus16), .ecc_mode(ecc_mode)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] mem [0:6];
  int         nack_at = -1;
  int         wr_idx = 0;
  int         ptr = 0;
  int         log_n = 0;
  logic [1:0] lop  [0:31];
  logic [7:0] ldat [0:31];
  logic       llast[0:31];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // byte engine and EEPROM model: one-cycle response latency
  initial begin
    cmd_ready = 1'b0; rsp_valid = 1'b0; rsp_data = 8'h00; rsp_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (cmd_valid === 1'b1) begin
        logic [1:0] op;
        logic [7:0] d;
        op = cmd_op; d = cmd_wdata;
        if (log_n < 32) begin
          lop[log_n] = op; ldat[log_n] = d; llast[log_n] = cmd_last;
        end
        log_n++;
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        rsp_ack = 1'b1; rsp_data = 8'h00;
        if (op == 2'd2) begin
          rsp_ack = (wr_idx != nack_at);
          if (wr_idx == 1 && rsp_ack) ptr = int'(d) - 8'h80;
          wr_idx++;
        end else if (op == 2'd3) begin
          rsp_data = (ptr >= 0 && ptr < 7) ? mem[ptr] : 8'hFF;
          ptr++;
        end
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  function automatic logic [1:0] exp_op(input int i);
    if (i == 0 || i == 3) return 2'd0;
    if (i == 1 || i == 2 || i == 4) return 2'd2;
    if (i >= 5 && i <= 11) return 2'd3;
    return 2'd1;
  endfunction

  function automatic logic [7:0] exp_dat(input int i);
    if (i == 1) return 8'hA0;
    if (i == 2) return 8'h80;
    if (i == 4) return 8'hA1;
    return 8'h00;
  endfunction

  task automatic load(input logic [7:0] b4, input logic [7:0] b5, input logic [7:0] b6);
    mem[0] = 8'h10; mem[1] = 8'hB3; mem[2] = 8'h57; mem[3] = 8'hA6;
    mem[4] = b4; mem[5] = b5; mem[6] = b6;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run(input string tag);
    log_n = 0; wr_idx = 0; ptr = 0;
    pulse_start();
    chk({tag, " R11 start clears done"}, {31'd0, done}, 32'd0);
    for (int k = 0; k < 400 && done !== 1'b1; k++) @(negedge clk);
  endtask

  task automatic chk_seq(input string tag, input int exp_n);
    chk({tag, " R2 command count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      logic [1:0] eo;
      eo = (i == exp_n - 1) ? 2'd1 : exp_op(i);
      chk($sformatf("%s R2 op %0d", tag, i), {30'd0, lop[i]}, {30'd0, eo});
      if (eo == 2'd2) chk($sformatf("%s R2 byte %0d", tag, i), {24'd0, ldat[i]}, {24'd0, exp_dat(i)});
      if (eo == 2'd3) chk($sformatf("%s R3 last %0d", tag, i), {31'd0, llast[i]}, {31'd0, i == 11});
    end
  endtask

  task automatic chk_good(input string tag, input int c, input int r, input int pe,
                          input int be, input int b16, input int ecc);
    chk({tag, " R10 done"}, {31'd0, done}, 32'd1);
    chk({tag, " R5 valid"}, {31'd0, valid}, 32'd1);
    chk({tag, " R10 err"}, {31'd0, err}, 32'd0);
    chk({tag, " R6 col"}, {28'd0, col_bytes}, c);
    chk({tag, " R6 row"}, {28'd0, row_bytes}, r);
    chk({tag, " R7 page"}, page_bytes, 32'd1 << pe);
    chk({tag, " R7 block"}, {16'd0, blk_pages}, 32'd1 << be);
    chk({tag, " R8 bus"}, {31'd0, bus16}, b16);
    chk({tag, " R8 ecc"}, {30'd0, ecc_mode}, ecc);
  endtask

  task automatic chk_reject(input string tag);
    chk({tag, " done"}, {31'd0, done}, 32'd1);
    chk({tag, " valid"}, {31'd0, valid}, 32'd0);
    chk({tag, " err"}, {31'd0, err}, 32'd1);
    chk({tag, " R10 zero page"}, page_bytes, 32'd0);
    chk({tag, " R10 zero fields"}, {col_bytes, row_bytes, blk_pages, bus16, ecc_mode}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 valid", {31'd0, valid}, 32'd0);
    chk("R1 err", {31'd0, err}, 32'd0);
    chk("R1 cmd_valid", {31'd0, cmd_valid}, 32'd0);
    chk("R1 page", page_bytes, 32'd0);
  endtask

  task automatic t_good_a();
    nack_at = -1; load(8'h23, 8'd11, 8'h26);
    run("good_a");
    chk_seq("good_a", 13);
    chk_good("good_a", 2, 3, 11, 6, 0, 1);
    repeat (20) @(negedge clk);
    chk("R11 done held", {31'd0, done}, 32'd1);
  endtask

  task automatic t_good_b();
    nack_at = -1; load(8'h12, 8'd12, 8'h57);
    run("good_b");
    chk_seq("good_b", 13);
    chk_good("good_b", 1, 2, 12, 7, 1, 2);
  endtask

  task automatic t_bad_sig();
    nack_at = -1; load(8'h23, 8'd11, 8'h26); mem[3] = 8'hA7;
    run("bad_sig");
    chk_seq("bad_sig", 13);
    chk_reject("R5 bad_sig");
  endtask

  task automatic t_ecc3();
    nack_at = -1; load(8'h23, 8'd11, 8'h66);
    run("ecc3");
    chk_reject("R9 ecc3");
  endtask

  task automatic t_big_page();
    nack_at = -1; load(8'h23, 8'd32, 8'h26);
    run("bigpage");
    chk_reject("R9 bigpage");
  endtask

  task automatic t_nack(input int which, input int exp_n);
    string tag;
    tag = $sformatf("R4 nack%0d", which);
    nack_at = which; load(8'h23, 8'd11, 8'h26);
    run(tag);
    chk_seq(tag, exp_n);
    chk_reject(tag);
  endtask

  task automatic t_start_busy();
    nack_at = -1; load(8'h34, 8'd9, 8'h25);
    log_n = 0; wr_idx = 0; ptr = 0;
    pulse_start();
    repeat (6) @(negedge clk);
    pulse_start();
    for (int k = 0; k < 400 && done !== 1'b1; k++) @(negedge clk);
    chk_seq("R11 busy_start", 13);
    chk_good("R11 busy_start", 3, 4, 9, 5, 0, 1);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_good_a();
    t_good_b();
    t_bad_sig();
    t_ecc3();
    t_big_page();
    t_nack(0, 3);
    t_nack(1, 4);
    t_nack(2, 6);
    t_good_a();
    t_start_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule